// File: doc/BRIEF.md
# DMA Descriptor Chaining Sequencer

This block is the control sequencer of a single DMA channel. It holds a current descriptor pointer, a pending next-list pointer and three status flags (run, halt, chain). It fetches one descriptor at a time through a request/response handshake. Each response gives a link pointer and two per-descriptor flags: chain-on-done and chain-on-finished. The block then waits for the attached transfer engine to report that the transfer stopped, either through a done event or through a finished event.

After each completion the sequencer takes exactly one of three actions. It advances to the linked descriptor, it chains to the pending list, or it halts. It chains when the list ends (the link is zero) or when a descriptor's flag matches the kind of event that stopped it. If the pending pointer is zero at that moment, it halts instead. Writing a nonzero pending pointer while the channel is stopped starts the channel on that list at once. A status write can also restart the channel from the current pointer.

The fetch request is a valid/ready stream. `fetch_valid` and `fetch_addr` stay asserted and unchanged until `fetch_ready` is seen high on a clock edge. The response side uses `resp_valid`/`resp_ready`. `resp_ready` is high only while the sequencer waits for a descriptor, and a response is taken on the first edge where both are high. The register write port, the flags and the events are plain level signals sampled on each clock edge.

Top module: `dma_chain_seq`

## Requirements
- R1: After reset, run, halt and chain are 0, both pointers are 0 and `fetch_valid` is 0.
- R2: When a completed descriptor makes no chain request and its link is nonzero, the link is loaded into the current pointer and that address is fetched next.
- R3: When the completed descriptor's link is zero and the pending pointer is nonzero, the current pointer takes the pending value, the pending pointer becomes zero, the chain flag is set, and the new address is fetched.
- R4: Whenever a chain is requested while the pending pointer is zero, the halt flag is set, run is cleared and no further fetch is issued.
- R5: A descriptor with chain-on-done set that stops on a done event chains, even when its link is nonzero.
- R6: A descriptor with chain-on-finished set that stops on a finished event chains in the same way. If done and finished arrive together, the stop counts as done. A flag of the other kind does not cause a chain.
- R7: A write of the pending pointer (wr_sel=1) while run is 1 only updates that pointer. Run and the current pointer are not affected.
- R8: A write of a nonzero pending pointer while run is 0 performs a chain: the current pointer takes the written value, the pending pointer is 0, chain and run are set, and a fetch starts. A write of zero while stopped only stores it.
- R9: A status write (wr_sel=2) with data bit 0 = 1 while stopped sets run and fetches from the current pointer. Data bit 1 = 0 clears halt and data bit 2 = 0 clears chain. Writing a 1 to bit 1 or bit 2 leaves that flag unchanged. Run is 1 exactly while the sequencer is not idle.
- R10: A write of the current pointer (wr_sel=0) takes effect only while run is 0 and is ignored while run is 1.
- R11: If a pending-pointer write lands in the same cycle as an internal chain, the chain uses the old pending value and the written value becomes the new pending pointer.
- R12: `fetch_valid` and `fetch_addr` hold steady while `fetch_ready` is low. Done and finished events are ignored unless the sequencer is waiting for one.
- R13: The two low bits of every written or loaded pointer are dropped (they read back as 0), so a link of 1 to 3 counts as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 current pointer, 1 pending pointer, 2 status |
| wr_data | input | PTR_W | Write data |
| cur_ptr | output | PTR_W | Current descriptor pointer |
| next_ptr | output | PTR_W | Pending next-list pointer |
| run | output | 1 | Channel running |
| halt | output | 1 | Sticky halt flag |
| chain | output | 1 | Sticky chain flag |
| fetch_valid | output | 1 | Descriptor fetch request |
| fetch_ready | input | 1 | Fetch request accepted |
| fetch_addr | output | PTR_W | Address of descriptor to fetch |
| resp_valid | input | 1 | Descriptor response valid |
| resp_ready | output | 1 | Sequencer waiting for a descriptor |
| resp_link | input | PTR_W | Link pointer of the fetched descriptor |
| resp_cod | input | 1 | Chain-on-done flag |
| resp_cof | input | 1 | Chain-on-finished flag |
| evt_done | input | 1 | Transfer stopped with done |
| evt_finished | input | 1 | Transfer stopped with finished |
| xfer_active | output | 1 | Waiting for a transfer to stop |

## Verification
The assertions check on every cycle that a stalled fetch request holds its address, that run tracks the non-idle state, and that every decision picks exactly one action. They also check that halting drops run, that a pending-pointer write while running keeps the channel running with the new value, and that a current-pointer write while running changes nothing. Only the bench's scenarios can show that the order of fetched addresses matches the rules. The bench sweeps the chain flags, the stopping event and the pending pointer around a mid-list descriptor and computes the expected address sequence for each case. Directed cases cover the same-cycle write collision, the sticky flags, and restarting the channel by a write.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT_DESC,
    ST_ACTIVE,
    ST_DECIDE
  } seq_state_t;

  typedef enum logic [1:0] {
    ACT_ADVANCE,
    ACT_CHAIN,
    ACT_HALT
  } seq_act_t;

  localparam logic [1:0] SEL_CUR  = 2'd0;
  localparam logic [1:0] SEL_NEXT = 2'd1;
  localparam logic [1:0] SEL_STAT = 2'd2;

  localparam int STAT_START_BIT = 0;
  localparam int STAT_HALT_BIT  = 1;
  localparam int STAT_CHAIN_BIT = 2;

endpackage

// File: rtl/dma_chain_decide.sv
module dma_chain_decide
  import dma_chain_pkg::*;
(
  input  logic     link_zero,
  input  logic     want_cod,
  input  logic     want_cof,
  input  logic     by_done,
  input  logic     next_zero,
  output seq_act_t act
);

  logic chain_req;

  // a stop counts as done when done was seen, otherwise as finished
  always_comb begin
    chain_req = link_zero
              | (by_done & want_cod)
              | (!by_done & want_cof);
    if (!chain_req)     act = ACT_ADVANCE;
    else if (next_zero) act = ACT_HALT;
    else                act = ACT_CHAIN;
  end

endmodule

// File: rtl/dma_chain_fsm.sv
module dma_chain_fsm
  import dma_chain_pkg::*;
#(
  parameter int PTR_W      = 32,
  parameter int ALIGN_BITS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             kick_req,
  input  logic             next_zero,
  input  logic             fetch_ready,
  input  logic             resp_valid,
  input  logic [PTR_W-1:0] resp_link,
  input  logic             resp_cod,
  input  logic             resp_cof,
  input  logic             evt_done,
  input  logic             evt_finished,
  output seq_state_t       state,
  output logic             fetch_valid,
  output logic             resp_ready,
  output logic             xfer_active,
  output logic [PTR_W-1:0] link_q,
  output logic             ld_link,
  output logic             do_chain,
  output logic             do_halt
);

  localparam logic [PTR_W-1:0] ALIGN_MASK =
    {{(PTR_W-ALIGN_BITS){1'b1}}, {ALIGN_BITS{1'b0}}};

  seq_state_t state_q, state_d;
  logic       cod_q, cof_q, by_done_q;
  seq_act_t   act;
  logic       link_zero;

  assign link_zero = (link_q & ALIGN_MASK) == '0;

  dma_chain_decide u_decide (
    .link_zero (link_zero),
    .want_cod  (cod_q),
    .want_cof  (cof_q),
    .by_done   (by_done_q),
    .next_zero (next_zero),
    .act       (act)
  );

  assign state       = state_q;
  assign fetch_valid = (state_q == ST_FETCH);
  assign resp_ready  = (state_q == ST_WAIT_DESC);
  assign xfer_active = (state_q == ST_ACTIVE);
  assign ld_link     = (state_q == ST_DECIDE) && (act == ACT_ADVANCE);
  assign do_chain    = (state_q == ST_DECIDE) && (act == ACT_CHAIN);
  assign do_halt     = (state_q == ST_DECIDE) && (act == ACT_HALT);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:      if (start_req || kick_req) state_d = ST_FETCH;
      ST_FETCH:     if (fetch_ready)           state_d = ST_WAIT_DESC;
      ST_WAIT_DESC: if (resp_valid)            state_d = ST_ACTIVE;
      ST_ACTIVE:    if (evt_done || evt_finished) state_d = ST_DECIDE;
      ST_DECIDE:    state_d = (act == ACT_HALT) ? ST_IDLE : ST_FETCH;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      link_q    <= '0;
      cod_q     <= 1'b0;
      cof_q     <= 1'b0;
      by_done_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_WAIT_DESC && resp_valid) begin
        link_q <= resp_link;
        cod_q  <= resp_cod;
        cof_q  <= resp_cof;
      end
      if (state_q == ST_ACTIVE && (evt_done || evt_finished))
        by_done_q <= evt_done;
    end
  end

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DECIDE) |-> $onehot({ld_link, do_chain, do_halt})); // R4

  AST_FETCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_ready) |=> fetch_valid); // R12

  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req || kick_req) |-> (state_q == ST_IDLE)); // R8

endmodule

// File: rtl/dma_chain_regs.sv
module dma_chain_regs
  import dma_chain_pkg::*;
#(
  parameter int PTR_W      = 32,
  parameter int ALIGN_BITS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [PTR_W-1:0] wr_data,
  input  logic             ld_link,
  input  logic [PTR_W-1:0] link_val,
  input  logic             do_chain,
  input  logic             do_halt,
  output logic [PTR_W-1:0] cur_ptr,
  output logic [PTR_W-1:0] next_ptr,
  output logic             run,
  output logic             halt,
  output logic             chain,
  output logic             start_req,
  output logic             kick_req,
  output logic             next_zero
);

  localparam logic [PTR_W-1:0] ALIGN_MASK =
    {{(PTR_W-ALIGN_BITS){1'b1}}, {ALIGN_BITS{1'b0}}};

  logic [PTR_W-1:0] wd_al, link_al;
  logic             wr_cur, wr_next, wr_stat;

  assign wd_al   = wr_data & ALIGN_MASK;
  assign link_al = link_val & ALIGN_MASK;
  assign wr_cur  = wr_en && (wr_sel == SEL_CUR);
  assign wr_next = wr_en && (wr_sel == SEL_NEXT);
  assign wr_stat = wr_en && (wr_sel == SEL_STAT);

  assign next_zero = (next_ptr == '0);
  assign kick_req  = wr_next && !run && (wd_al != '0);
  assign start_req = wr_stat && !run && wr_data[STAT_START_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_ptr  <= '0;
      next_ptr <= '0;
      run      <= 1'b0;
      halt     <= 1'b0;
      chain    <= 1'b0;
    end else begin
      // current pointer: hardware loads first, software only when stopped
      if (kick_req)             cur_ptr <= wd_al;
      else if (do_chain)        cur_ptr <= next_ptr;
      else if (ld_link)         cur_ptr <= link_al;
      else if (wr_cur && !run)  cur_ptr <= wd_al;

      // pending pointer: a same-cycle write survives the chain clear
      if (kick_req)             next_ptr <= '0;
      else if (wr_next)         next_ptr <= wd_al;
      else if (do_chain)        next_ptr <= '0;

      if (kick_req || start_req) run <= 1'b1;
      else if (do_halt)          run <= 1'b0;

      if (do_halt)                                 halt <= 1'b1;
      else if (wr_stat && !wr_data[STAT_HALT_BIT]) halt <= 1'b0;

      if (do_chain || kick_req)                     chain <= 1'b1;
      else if (wr_stat && !wr_data[STAT_CHAIN_BIT]) chain <= 1'b0;
    end
  end

  AST_NEXT_WR_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_next && run && !do_halt) |=> (run && next_ptr == $past(wd_al))); // R7

  AST_CUR_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cur && run && !ld_link && !do_chain) |=> (cur_ptr == $past(cur_ptr))); // R10

  AST_HALT_STOPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt) |-> !run); // R4

endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
  import dma_chain_pkg::*;
#(
  parameter int PTR_W      = 32,
  parameter int ALIGN_BITS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [PTR_W-1:0] wr_data,
  output logic [PTR_W-1:0] cur_ptr,
  output logic [PTR_W-1:0] next_ptr,
  output logic             run,
  output logic             halt,
  output logic             chain,
  output logic             fetch_valid,
  input  logic             fetch_ready,
  output logic [PTR_W-1:0] fetch_addr,
  input  logic             resp_valid,
  output logic             resp_ready,
  input  logic [PTR_W-1:0] resp_link,
  input  logic             resp_cod,
  input  logic             resp_cof,
  input  logic             evt_done,
  input  logic             evt_finished,
  output logic             xfer_active
);

  seq_state_t       state;
  logic [PTR_W-1:0] link_q;
  logic             ld_link, do_chain, do_halt;
  logic             start_req, kick_req, next_zero;

  dma_chain_regs #(.PTR_W(PTR_W), .ALIGN_BITS(ALIGN_BITS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .ld_link   (ld_link),
    .link_val  (link_q),
    .do_chain  (do_chain),
    .do_halt   (do_halt),
    .cur_ptr   (cur_ptr),
    .next_ptr  (next_ptr),
    .run       (run),
    .halt      (halt),
    .chain     (chain),
    .start_req (start_req),
    .kick_req  (kick_req),
    .next_zero (next_zero)
  );

  dma_chain_fsm #(.PTR_W(PTR_W), .ALIGN_BITS(ALIGN_BITS)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_req    (start_req),
    .kick_req     (kick_req),
    .next_zero    (next_zero),
    .fetch_ready  (fetch_ready),
    .resp_valid   (resp_valid),
    .resp_link    (resp_link),
    .resp_cod     (resp_cod),
    .resp_cof     (resp_cof),
    .evt_done     (evt_done),
    .evt_finished (evt_finished),
    .state        (state),
    .fetch_valid  (fetch_valid),
    .resp_ready   (resp_ready),
    .xfer_active  (xfer_active),
    .link_q       (link_q),
    .ld_link      (ld_link),
    .do_chain     (do_chain),
    .do_halt      (do_halt)
  );

  assign fetch_addr = cur_ptr;

  AST_FETCH_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_ready) |=> $stable(fetch_addr)); // R12

  AST_RUN_TRACKS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    run == (state != ST_IDLE)); // R9

endmodule

// File: tb/sim_dma_chain_seq.sv
module sim_dma_chain_seq;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data;
  logic [31:0] cur_ptr, next_ptr, fetch_addr;
  logic        run, halt, chain, fetch_valid, fetch_ready;
  logic        resp_valid, resp_ready, resp_cod, resp_cof;
  logic [31:0] resp_link;
  logic        evt_done, evt_finished, xfer_active;

  int n_cmp = 0;
  int n_bad = 0;

  logic [31:0] m_link [16];
  logic        m_cod  [16];
  logic        m_cof  [16];
  logic        m_fin  [16];
  logic        m_both [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chain_seq u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cur_ptr(cur_ptr), .next_ptr(next_ptr), .run(run), .halt(halt), .chain(chain),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_addr(fetch_addr),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_link(resp_link),
    .resp_cod(resp_cod), .resp_cof(resp_cof), .evt_done(evt_done),
    .evt_finished(evt_finished), .xfer_active(xfer_active)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0;
    fetch_ready = 1'b0; resp_valid = 1'b0; resp_link = '0;
    resp_cod = 1'b0; resp_cof = 1'b0; evt_done = 1'b0; evt_finished = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 2'd3;
  endtask

  // entered at a negedge with a fetch pending; returns at the negedge after the decision
  task automatic serve(input logic [31:0] link, input logic cod, input logic cof,
                       input logic dn, input logic fn, input int stall,
                       input logic late_wr, input logic [31:0] late_val);
    logic [31:0] a0;
    a0 = fetch_addr;
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk("R12 fetch held", {31'd0, fetch_valid}, 32'd1);
      chk("R12 addr held", fetch_addr, a0);
    end
    fetch_ready = 1'b1;
    @(negedge clk);
    fetch_ready = 1'b0;
    resp_valid = 1'b1; resp_link = link; resp_cod = cod; resp_cof = cof;
    chk("R12 resp_ready", {31'd0, resp_ready}, 32'd1);
    @(negedge clk);
    resp_valid = 1'b0;
    evt_done = dn; evt_finished = fn;
    @(negedge clk);
    evt_done = 1'b0; evt_finished = 1'b0;
    if (late_wr) begin
      wr_en = 1'b1; wr_sel = 2'd1; wr_data = late_val;
    end
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 2'd3;
  endtask

  task automatic sweep(input int sw);
    logic [31:0] e_addr [8];
    string       e_tag  [8];
    logic [31:0] cur, nx, nval, lk;
    logic        ch, byd, req;
    int          cnt, idx;
    string       nt;
    for (int i = 0; i < 16; i++) begin
      m_link[i] = '0; m_cod[i] = 0; m_cof[i] = 0; m_fin[i] = 0; m_both[i] = 0;
    end
    m_link[1] = 32'd9;                        // A -> B, low bits set
    m_link[2] = 32'd12;                       // B -> C
    m_link[3] = 32'd3;                        // C ends (link reads as zero)
    m_link[8] = 32'd36; m_fin[8] = 1;         // X -> Y
    m_link[9] = 32'd0;  m_fin[9] = 1; m_cof[9] = 1;
    if (sw < 16) begin
      m_cod[2] = sw[0]; m_cof[2] = sw[1]; m_fin[2] = sw[2];
      nval = sw[3] ? 32'd32 : 32'd2;
    end else begin
      m_cof[2] = 1; m_fin[2] = 1; m_both[2] = 1;
      nval = 32'd32;
    end
    // expected fetch order computed from the rules
    cur = 32'd4; nx = nval & 32'hFFFF_FFFC; ch = 0; cnt = 0; nt = "R9";
    for (int k = 0; k < 8; k++) begin
      e_addr[k] = cur; e_tag[k] = nt; cnt++;
      idx = cur[5:2];
      lk  = m_link[idx] & 32'hFFFF_FFFC;
      byd = m_both[idx] || !m_fin[idx];
      req = (lk == 0) || (byd && m_cod[idx]) || (!byd && m_cof[idx]);
      if (!req) begin
        cur = lk; nt = "R2";
      end else if (nx != 0) begin
        nt = (byd && m_cod[idx]) ? "R5" : ((!byd && m_cof[idx]) ? "R6" : "R3");
        cur = nx; nx = 0; ch = 1;
      end else break;
    end
    do_reset();
    wr(2'd0, 32'd4);
    wr(2'd2, 32'd1);
    wr(2'd1, nval);
    chk("R13 R7 pending readback", next_ptr, nval & 32'hFFFF_FFFC);
    for (int i = 0; i < cnt; i++) begin
      chk({e_tag[i], " fetch valid"}, {31'd0, fetch_valid}, 32'd1);
      chk({e_tag[i], " fetch addr"}, fetch_addr, e_addr[i]);
      idx = e_addr[i][5:2];
      serve(m_link[idx], m_cod[idx], m_cof[idx],
            m_both[idx] || !m_fin[idx], m_fin[idx], i % 3, 1'b0, 32'd0);
    end
    chk("R4 halted run", {31'd0, run}, 32'd0);
    chk("R4 halt flag", {31'd0, halt}, 32'd1);
    chk("R4 no fetch", {31'd0, fetch_valid}, 32'd0);
    chk("R3 chain flag", {31'd0, chain}, {31'd0, ch});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 run", {31'd0, run}, 32'd0);
    chk("R1 halt", {31'd0, halt}, 32'd0);
    chk("R1 chain", {31'd0, chain}, 32'd0);
    chk("R1 cur", cur_ptr, 32'd0);
    chk("R1 next", next_ptr, 32'd0);
    chk("R1 fetch", {31'd0, fetch_valid}, 32'd0);
    // R8 zero write while idle only stores (R13: 3 aligns to 0)
    wr(2'd1, 32'd3);
    chk("R8 zero write no run", {31'd0, run}, 32'd0);
    chk("R13 low bits dropped", next_ptr, 32'd0);
    // R8 kick
    wr(2'd1, 32'h41);
    chk("R8 kick cur", cur_ptr, 32'h40);
    chk("R8 kick next", next_ptr, 32'd0);
    chk("R8 kick chain", {31'd0, chain}, 32'd1);
    chk("R8 kick run", {31'd0, run}, 32'd1);
    chk("R8 kick fetch", {31'd0, fetch_valid}, 32'd1);
    // R10 current write ignored while running
    wr(2'd0, 32'h80);
    chk("R10 cur kept", cur_ptr, 32'h40);
    // R7 pending write while running
    wr(2'd1, 32'h44);
    chk("R7 next updated", next_ptr, 32'h44);
    chk("R7 cur kept", cur_ptr, 32'h40);
    chk("R7 still fetching", {31'd0, fetch_valid}, 32'd1);
    // R12 event outside active wait
    evt_done = 1'b1;
    @(negedge clk);
    evt_done = 1'b0;
    chk("R12 event ignored", {31'd0, fetch_valid}, 32'd1);
    chk("R12 event ignored addr", fetch_addr, 32'h40);
    // R11 write collides with list-end chain
    serve(32'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1, 1'b1, 32'h60);
    chk("R11 cur takes old", cur_ptr, 32'h44);
    chk("R11 next keeps write", next_ptr, 32'h60);
    chk("R11 fetch addr", fetch_addr, 32'h44);
    chk("R11 run", {31'd0, run}, 32'd1);
    // R9 status clears chain
    wr(2'd2, 32'd0);
    chk("R9 chain cleared", {31'd0, chain}, 32'd0);
    chk("R9 run kept", {31'd0, run}, 32'd1);
    wr(2'd1, 32'd0);
    serve(32'd0, 1'b0, 1'b0, 1'b1, 1'b0, 0, 1'b0, 32'd0);
    chk("R4 halt", {31'd0, halt}, 32'd1);
    chk("R4 run cleared", {31'd0, run}, 32'd0);
    wr(2'd2, 32'd2);
    chk("R9 halt sticky", {31'd0, halt}, 32'd1);
    wr(2'd2, 32'd0);
    chk("R9 halt cleared", {31'd0, halt}, 32'd0);
    wr(2'd0, 32'h48);
    chk("R10 idle cur write", cur_ptr, 32'h48);
    wr(2'd2, 32'd1);
    chk("R9 start run", {31'd0, run}, 32'd1);
    chk("R9 start addr", fetch_addr, 32'h48);
    chk("R9 start chain", {31'd0, chain}, 32'd0);
    // sweep around the mid-list descriptor
    for (int sw = 0; sw < 17; sw++) sweep(sw);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule